// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table held in ordinary memory. A requester raises a translate request with the virtual address, whether the access is a write, and whether it comes from user mode. The walker also takes the frame number of the top-level table (the directory root). It then issues word reads on a simple request/acknowledge memory port: first the directory entry, then the leaf entry. It checks presence and permissions in both entries. On success it sets the accessed flag, and on a write the dirty flag, in the leaf entry, storing the entry back only if a flag actually changed.

The result is a one-cycle `done` pulse with the physical address and a 2-bit fault code. The virtual address splits into a directory index in bits [31:22], a table index in bits [21:12] and a 12-bit byte offset in bits [11:0]. Each table holds 1024 four-byte entries and so fills one 4 KB frame. In every entry, bits [31:12] carry a frame number. The flag bits are: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed and bit 6 dirty.

Top module: `pt_walker`

## Requirements
- R1: After reset, and while no request is pending, `done` and `mem_req` are 0, and `fault` and `paddr` read 0.
- R2: The directory entry is read from word address {root frame, VA[31:22], 2'b00}. The leaf entry is read from {directory entry bits [31:12], VA[21:12], 2'b00}.
- R3: A directory entry with bit 0 (present) clear ends the walk after that single read with fault code 2'b01 (not present), and no further memory access is made.
- R4: A leaf entry with bit 0 clear gives fault code 2'b01 and causes no memory write.
- R5: A write gives fault code 2'b10 (write-protect) when bit 1 is clear in the directory entry or in the leaf entry. When a user-protect violation is also present, the write-protect code is the one reported.
- R6: A user-mode access gives fault code 2'b11 (user-protect) when bit 2 is clear in the directory entry or in the leaf entry.
- R7: On success the fault code is 2'b00 and `paddr` is {leaf bits [31:12], VA[11:0]}. On any fault, `paddr` is 0.
- R8: On success, the stored leaf entry gains bit 5 (accessed), and on a write also bit 6 (dirty). The entry is written back to the address it was read from only when its value changes. A faulting walk writes nothing.
- R9: A walk that is not stopped at the directory makes exactly two memory reads. Each memory request holds its address and kind steady until `mem_ack`, and every address is word aligned.
- R10: `done` is high for exactly one cycle per request, and `fault`/`paddr` hold their values afterwards. The address, access kind and root frame are captured when the request is accepted, so later changes to them do not affect the walk in progress.
- R11: A kernel-mode read succeeds whatever the writable and user bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translate request, held until `done` |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| dir_root | input | 20 | Frame number of the directory table |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 2 | 00 none, 01 not present, 10 write-protect, 11 user-protect |
| paddr | output | 32 | Translated physical address (0 on fault) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data (updated leaf entry) |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
A vector table drives reads and writes from both privilege levels. It uses leaf entries that are fresh, already accessed, or already dirty, which separates the write-back cases from the no-write cases. Fault cases clear the present, writable or user bit in each of the two levels in turn. This shows whether a walk stops at the directory or at the leaf, and whether directory permissions are combined with leaf permissions. A combined write-plus-user violation fixes the reporting priority. A directed walk moves the directory root elsewhere and changes the root input in the middle of the walk, proving that the root is captured when the request is accepted.

// File: rtl/pt_walker_pkg.sv
`timescale 1ns/1ps
package pt_walker_pkg;

    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned IDX_W    = 10;
    localparam int unsigned OFF_W    = 12;
    localparam int unsigned ENT_LG   = 2;
    localparam int unsigned FRAME_W  = ADDR_W - OFF_W;

    localparam int unsigned FLG_PRES = 0;
    localparam int unsigned FLG_WR   = 1;
    localparam int unsigned FLG_USR  = 2;
    localparam int unsigned FLG_ACC  = 5;
    localparam int unsigned FLG_DRT  = 6;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_WRPROT  = 2'd2,
        FLT_USRPROT = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_LEAF,
        ST_WB,
        ST_DONE
    } walk_st_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  vaddr;
        logic               wr;
        logic               usr;
        logic [FRAME_W-1:0] root;
    } walk_req_t;

    function automatic logic [IDX_W-1:0] dir_index(input logic [ADDR_W-1:0] va);
        return va[ADDR_W-1 -: IDX_W];
    endfunction

    function automatic logic [IDX_W-1:0] leaf_index(input logic [ADDR_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [FRAME_W-1:0] frame,
                                                    input logic [IDX_W-1:0] idx);
        return {frame, idx, {ENT_LG{1'b0}}};
    endfunction

    function automatic logic [FRAME_W-1:0] frame_of(input logic [ADDR_W-1:0] ent);
        return ent[ADDR_W-1:OFF_W];
    endfunction

endpackage

// File: rtl/pw_addr_gen.sv
`timescale 1ns/1ps
module pw_addr_gen
    import pt_walker_pkg::*;
(
    input  walk_st_e           st,
    input  logic [FRAME_W-1:0] root,
    input  logic [FRAME_W-1:0] leaf_tbl,
    input  logic [ADDR_W-1:0]  vaddr,
    output logic [ADDR_W-1:0]  addr
);
    always_comb begin
        case (st)
            ST_DIR:  addr = slot_addr(root, dir_index(vaddr));
            default: addr = slot_addr(leaf_tbl, leaf_index(vaddr));
        endcase
    end
endmodule

// File: rtl/pw_entry_check.sv
`timescale 1ns/1ps
module pw_entry_check
    import pt_walker_pkg::*;
(
    input  logic [ADDR_W-1:0] leaf,
    input  logic              dir_wr_ok,
    input  logic              dir_usr_ok,
    input  logic              wr,
    input  logic              usr,
    output fault_e            flt,
    output logic [ADDR_W-1:0] leaf_upd,
    output logic              wb_need
);
    logic eff_wr;
    logic eff_usr;

    always_comb begin
        eff_wr  = dir_wr_ok  & leaf[FLG_WR];
        eff_usr = dir_usr_ok & leaf[FLG_USR];
        if (!leaf[FLG_PRES])
            flt = FLT_ABSENT;
        else if (wr && !eff_wr)
            flt = FLT_WRPROT;
        else if (usr && !eff_usr)
            flt = FLT_USRPROT;
        else
            flt = FLT_NONE;

        leaf_upd          = leaf;
        leaf_upd[FLG_ACC] = 1'b1;
        if (wr)
            leaf_upd[FLG_DRT] = 1'b1;
        wb_need = (flt == FLT_NONE) && (leaf_upd != leaf);
    end
endmodule

// File: rtl/pw_walk_ctrl.sv
`timescale 1ns/1ps
module pw_walk_ctrl
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] dir_root,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata,
    input  fault_e             chk_flt,
    input  logic [ADDR_W-1:0]  chk_upd,
    input  logic               chk_wb,
    output walk_st_e           st,
    output walk_req_t          rq,
    output logic [FRAME_W-1:0] leaf_tbl,
    output logic               dir_wr_ok,
    output logic               dir_usr_ok,
    output logic [ADDR_W-1:0]  wb_data,
    output fault_e             flt_q,
    output logic [ADDR_W-1:0]  pa_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            rq         <= '0;
            leaf_tbl   <= '0;
            dir_wr_ok  <= 1'b0;
            dir_usr_ok <= 1'b0;
            wb_data    <= '0;
            flt_q      <= FLT_NONE;
            pa_q       <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        rq.vaddr <= req_vaddr;
                        rq.wr    <= req_write;
                        rq.usr   <= req_user;
                        rq.root  <= dir_root;
                        st       <= ST_DIR;
                    end
                end
                ST_DIR: begin
                    if (mem_ack) begin
                        leaf_tbl   <= frame_of(mem_rdata);
                        dir_wr_ok  <= mem_rdata[FLG_WR];
                        dir_usr_ok <= mem_rdata[FLG_USR];
                        if (!mem_rdata[FLG_PRES]) begin
                            flt_q <= FLT_ABSENT;
                            pa_q  <= '0;
                            st    <= ST_DONE;
                        end else begin
                            st <= ST_LEAF;
                        end
                    end
                end
                ST_LEAF: begin
                    if (mem_ack) begin
                        wb_data <= chk_upd;
                        flt_q   <= chk_flt;
                        if (chk_flt == FLT_NONE)
                            pa_q <= {frame_of(mem_rdata), rq.vaddr[OFF_W-1:0]};
                        else
                            pa_q <= '0;
                        st <= chk_wb ? ST_WB : ST_DONE;
                    end
                end
                ST_WB: begin
                    if (mem_ack)
                        st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [FRAME_W-1:0] dir_root,
    output logic               done,
    output logic [1:0]         fault,
    output logic [ADDR_W-1:0]  paddr,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [ADDR_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    input  logic [ADDR_W-1:0]  mem_rdata
);
    walk_st_e           st;
    walk_req_t          rq;
    logic [FRAME_W-1:0] leaf_tbl;
    logic               dir_wr_ok;
    logic               dir_usr_ok;
    logic [ADDR_W-1:0]  wb_data;
    fault_e             flt_q;
    logic [ADDR_W-1:0]  pa_q;
    fault_e             chk_flt;
    logic [ADDR_W-1:0]  chk_upd;
    logic               chk_wb;

    pw_walk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .req_write (req_write),
        .req_user  (req_user),
        .dir_root  (dir_root),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .chk_flt   (chk_flt),
        .chk_upd   (chk_upd),
        .chk_wb    (chk_wb),
        .st        (st),
        .rq        (rq),
        .leaf_tbl  (leaf_tbl),
        .dir_wr_ok (dir_wr_ok),
        .dir_usr_ok(dir_usr_ok),
        .wb_data   (wb_data),
        .flt_q     (flt_q),
        .pa_q      (pa_q)
    );

    pw_entry_check u_check (
        .leaf      (mem_rdata),
        .dir_wr_ok (dir_wr_ok),
        .dir_usr_ok(dir_usr_ok),
        .wr        (rq.wr),
        .usr       (rq.usr),
        .flt       (chk_flt),
        .leaf_upd  (chk_upd),
        .wb_need   (chk_wb)
    );

    pw_addr_gen u_addr (
        .st       (st),
        .root     (rq.root),
        .leaf_tbl (leaf_tbl),
        .vaddr    (rq.vaddr),
        .addr     (mem_addr)
    );

    assign mem_req   = (st == ST_DIR) || (st == ST_LEAF) || (st == ST_WB);
    assign mem_we    = (st == ST_WB);
    assign mem_wdata = wb_data;
    assign done      = (st == ST_DONE);
    assign fault     = flt_q;
    assign paddr     = pa_q;
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] req_vaddr,
    input logic        req_write,
    input logic        done,
    input logic [1:0]  fault,
    input logic [31:0] paddr,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata
);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    word_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R8
    wb_accessed_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> mem_wdata[5]);

    // R8
    wb_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && req_write) |-> mem_wdata[6]);

    // R7
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault != 2'b00) |-> (paddr == 32'h0));

    // R7
    offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && fault == 2'b00) |-> (paddr[11:0] == req_vaddr[11:0]));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        req_write;
    logic        req_user;
    logic [19:0] dir_root;
    logic        done;
    logic [1:0]  fault;
    logic [31:0] paddr;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #2.5 clk = ~clk;

    pt_walker dut (.*);

    // word memory, index = byte address [13:2]
    logic [31:0] mem [0:4095];
    int nrd = 0;
    int nwr = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack)
                mem_rdata <= mem[mem_addr[13:2]];
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    nwr <= nwr + 1;
                end else begin
                    nrd <= nrd + 1;
                end
            end
        end
    end

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic        wr;
        logic        us;
        logic [31:0] dent;
        logic [31:0] leaf;
        logic [1:0]  flt;
        logic [31:0] pa;
        logic [31:0] after;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{32'h12345678, 1'b0, 1'b0, 32'h00002007, 32'h00ABC003, 2'd0, 32'h00ABC678, 32'h00ABC023},
        '{32'h12345678, 1'b1, 1'b1, 32'h00002007, 32'h00ABC007, 2'd0, 32'h00ABC678, 32'h00ABC067},
        '{32'h00400010, 1'b1, 1'b0, 32'h00002007, 32'h00123063, 2'd0, 32'h00123010, 32'h00123063},
        '{32'hFFC00ABC, 1'b0, 1'b0, 32'h00002006, 32'h00555007, 2'd1, 32'h00000000, 32'h00555007},
        '{32'h00801FFF, 1'b0, 1'b0, 32'h00002003, 32'h00777006, 2'd1, 32'h00000000, 32'h00777006},
        '{32'h00C02004, 1'b1, 1'b0, 32'h00002007, 32'h00888005, 2'd2, 32'h00000000, 32'h00888005},
        '{32'h01003100, 1'b0, 1'b1, 32'h00002007, 32'h00999003, 2'd3, 32'h00000000, 32'h00999003},
        '{32'h01404000, 1'b1, 1'b1, 32'h00002007, 32'h00AAA001, 2'd2, 32'h00000000, 32'h00AAA001},
        '{32'h01805000, 1'b1, 1'b0, 32'h00002005, 32'h00BBB003, 2'd2, 32'h00000000, 32'h00BBB003},
        '{32'h01C06000, 1'b0, 1'b1, 32'h00002003, 32'h00CCC007, 2'd3, 32'h00000000, 32'h00CCC007},
        '{32'h02007FFC, 1'b0, 1'b0, 32'h00002001, 32'h00DDD001, 2'd0, 32'h00DDDFFC, 32'h00DDD021}
    };

    string tags [NV] = '{"R7/R8 kernel read", "R8 user write", "R8 no-change",
                         "R3 dir absent", "R4 leaf absent", "R5 leaf read-only",
                         "R6 leaf kernel-only", "R5 priority", "R5 dir read-only",
                         "R6 dir kernel-only", "R11 kernel read"};

    task automatic wait_done(output bit ok);
        int cyc = 0;
        ok = 1'b0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        ok = done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        bit ok;
        int r0, w0;
        for (int k = 0; k < 4096; k++) mem[k] = 32'h0;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        req_user = 1'b0; dir_root = 20'h00001;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check("R1 done", {31'b0, done}, 32'h0);
        check("R1 mem_req", {31'b0, mem_req}, 32'h0);
        check("R1 fault", {30'b0, fault}, 32'h0);
        check("R1 paddr", paddr, 32'h0);

        for (int i = 0; i < NV; i++) begin
            mem[1024 + int'(VEC[i].va[31:22])] = VEC[i].dent;
            mem[2048 + int'(VEC[i].va[21:12])] = VEC[i].leaf;
            r0 = nrd; w0 = nwr;
            req_vaddr = VEC[i].va; req_write = VEC[i].wr; req_user = VEC[i].us;
            req_valid = 1'b1;
            @(negedge clk);
            wait_done(ok);
            check({tags[i], " done"}, {31'b0, ok}, 32'h1);
            check({tags[i], " fault"}, {30'b0, fault}, {30'b0, VEC[i].flt});
            check({tags[i], " paddr"}, paddr, VEC[i].pa);
            req_valid = 1'b0;
            @(negedge clk);
            // R10: single-cycle pulse, result held
            check({tags[i], " R10 pulse"}, {31'b0, done}, 32'h0);
            check({tags[i], " R10 hold"}, paddr, VEC[i].pa);
            check({tags[i], " entry"}, mem[2048 + int'(VEC[i].va[21:12])], VEC[i].after);
            // R9 / R3: read count; R8 / R4: write count
            check({tags[i], " R9 reads"}, nrd - r0,
                  (VEC[i].dent[0] ? 32'd2 : 32'd1));
            check({tags[i], " R8 writes"}, nwr - w0,
                  (VEC[i].after != VEC[i].leaf) ? 32'd1 : 32'd0);
        end

        // R10 / R2: root captured on accept, alternative root frame
        mem[3072 + 32'h48] = 32'h00002007;
        mem[1024 + 32'h48] = 32'h00000000;
        mem[2048 + 32'h345] = 32'h00EEE003;
        dir_root = 20'h00003;
        req_vaddr = 32'h12345678; req_write = 1'b0; req_user = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        dir_root = 20'h00001;
        req_vaddr = 32'h00000000;
        @(negedge clk);
        req_vaddr = 32'h12345678;
        wait_done(ok);
        check("R10 captured root done", {31'b0, ok}, 32'h1);
        check("R2 alt root fault", {30'b0, fault}, 32'h0);
        check("R2 alt root paddr", paddr, 32'h00EEE678);
        req_valid = 1'b0;
        @(negedge clk);

        // R1: no request, no memory traffic
        r0 = nrd;
        repeat (10) @(negedge clk);
        check("R1 idle reads", nrd - r0, 32'd0);
        check("R1 idle mem_req", {31'b0, mem_req}, 32'h0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule